// File: doc/BRIEF.md
# Page Permission and Fault Status Unit

This unit sits behind the page table walker of a 32-bit memory management unit. Once the walker holds the final page table entry, it gives this unit four things: the entry's 3-bit permission code, its modified bit, the kind of access, and the privilege level. The unit then decides at once whether the access may proceed. It reports either a fault type or the read, write and execute rights that may be cached for the page.

When a checked access faults, the unit does three things:
- It records the fault in an 8-bit status register, together with the page-aligned fault address.
- It emits a one-cycle trap pulse, tagged as an instruction fault or a data fault.

Software reads the status through a plain read strobe. The read also clears the register. A no-fault mode lets user-level accesses proceed silently in place of trapping.

Top module: `mmu_access_check`

## Requirements
- R1: The access index is {store, fetch, supervisor}, with bit 2 set for a store, bit 1 set for an instruction fetch and bit 0 set for supervisor level. Access kind encodings are 0 = load, 1 = store and 2 = instruction fetch, so a user load has index 0 and a supervisor store has index 5.
- R2: A user-level access to a page with permission code 6 or 7 gives fault type 3 (privilege), whatever the access kind.
- R3: Fault type 2 (protection) is reported when the rights of the permission code lack the right the access needs: read for a load, write for a store, execute for a fetch. Fault type 0 means the access is allowed.
- R4: User rights by code: 0=R, 1=RW, 2=RX, 3=RWX, 4=X, 5=R, 6 and 7 = none. Supervisor rights are the same for codes 0 to 4; code 5=RW, 6=RX, 7=RWX.
- R5: The write right is never granted while the entry's modified bit is 0. This withholding does not by itself cause a fault.
- R6: With no-fault mode on, a user-level access reports fault type 0 and causes no trap, no status change and no address change. Supervisor faults are unaffected by no-fault mode.
- R7: A fault on a zero status register loads it with index in bits 7:5, fault type in bits 4:2, bit 1 set and bit 0 clear. The update is visible the cycle after the check.
- R8: A fault on a nonzero status register first reduces it to bit 0 alone, then merges the new fields as in R7. The result has bit 0 (overwrite) set.
- R9: On a fault, the fault address register takes the access address with its low 12 bits cleared, in the same cycle as the status update. Otherwise it holds its value.
- R10: A read strobe presents the status on the status output and clears the register at the next edge. A fault in the same cycle takes precedence: the register takes the fault update, computed from its pre-read value.
- R11: A fault produces a trap pulse in the next cycle, lasting exactly one cycle per faulting check. The fetch tag is high with it only for instruction fetches.
- R12: After reset the status and fault address registers are zero and the trap outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chk_valid_i | input | 1 | A check is made this cycle; faults update the registers |
| acc_kind_i | input | 2 | 0 load, 1 store, 2 instruction fetch |
| supervisor_i | input | 1 | Access is at supervisor level |
| perm_code_i | input | 3 | Permission code of the final table entry |
| modified_i | input | 1 | Entry's modified bit |
| nofault_en_i | input | 1 | No-fault mode enable |
| vaddr_i | input | ADDR_W | Access address |
| sts_rd_i | input | 1 | Software read strobe for the status register |
| fault_type_o | output | 3 | Effective fault type (0, 2 or 3) |
| grant_r_o | output | 1 | Read right granted |
| grant_w_o | output | 1 | Write right granted |
| grant_x_o | output | 1 | Execute right granted |
| trap_o | output | 1 | One-cycle trap pulse |
| trap_fetch_o | output | 1 | Trap is an instruction fault |
| status_o | output | 8 | Fault status register |
| fault_addr_o | output | ADDR_W | Fault address register |

## Verification
The assertions assume several things about the inputs:
- The access kind is never 3.
- The inputs are stable and known during any cycle with a check or a read strobe.
- The read strobe is sampled only in the cycles in which it is high.

The stimulus keeps to these rules. It drives only the three defined kinds, changes every input at the falling edge, and holds the strobes for exactly one cycle. The permission table is walked with the check strobe low, so that those combinational checks leave the registers untouched. The register behaviour is then exercised in directed sequences whose expected status words follow from the field layout in R7 and R8.

// File: rtl/mmu_chk_pkg.sv
package mmu_chk_pkg;
  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2
  } acc_kind_e;

  localparam logic [2:0] FT_NONE = 3'd0;
  localparam logic [2:0] FT_PROT = 3'd2;
  localparam logic [2:0] FT_PRIV = 3'd3;

  localparam int STS_W = 8;

  typedef struct packed {
    logic r;
    logic w;
    logic x;
  } rights_t;
endpackage

// File: rtl/mmu_perm_decode.sv
module mmu_perm_decode
  import mmu_chk_pkg::*;
(
  input  logic [1:0] kind_i,
  input  logic       super_i,
  input  logic [2:0] code_i,
  input  logic       modified_i,
  input  logic       nofault_i,
  output logic [2:0] idx_o,
  output logic [2:0] ft_o,
  output rights_t    grant_o
);
  rights_t raw;
  logic    needed_ok;
  logic [2:0] raw_ft;

  always_comb begin
    case (code_i)
      3'd0:    raw = '{r: 1'b1, w: 1'b0, x: 1'b0};
      3'd1:    raw = '{r: 1'b1, w: 1'b1, x: 1'b0};
      3'd2:    raw = '{r: 1'b1, w: 1'b0, x: 1'b1};
      3'd3:    raw = '{r: 1'b1, w: 1'b1, x: 1'b1};
      3'd4:    raw = '{r: 1'b0, w: 1'b0, x: 1'b1};
      3'd5:    raw = super_i ? '{r: 1'b1, w: 1'b1, x: 1'b0} : '{r: 1'b1, w: 1'b0, x: 1'b0};
      3'd6:    raw = super_i ? '{r: 1'b1, w: 1'b0, x: 1'b1} : '{r: 1'b0, w: 1'b0, x: 1'b0};
      default: raw = super_i ? '{r: 1'b1, w: 1'b1, x: 1'b1} : '{r: 1'b0, w: 1'b0, x: 1'b0};
    endcase
  end

  always_comb begin
    case (kind_i)
      ACC_STORE: needed_ok = raw.w;
      ACC_FETCH: needed_ok = raw.x;
      default:   needed_ok = raw.r;
    endcase
  end

  assign raw_ft = (!super_i && code_i[2:1] == 2'b11) ? FT_PRIV :
                  (!needed_ok)                       ? FT_PROT : FT_NONE;

  assign ft_o  = (nofault_i && !super_i) ? FT_NONE : raw_ft;
  assign idx_o = {kind_i == ACC_STORE, kind_i == ACC_FETCH, super_i};

  assign grant_o = '{r: raw.r, w: raw.w & modified_i, x: raw.x};
endmodule

// File: rtl/mmu_fault_regs.sv
module mmu_fault_regs
  import mmu_chk_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fault_i,
  input  logic [2:0]        idx_i,
  input  logic [2:0]        ft_i,
  input  logic              fetch_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              sts_rd_i,
  output logic [STS_W-1:0]  sts_o,
  output logic [ADDR_W-1:0] far_o,
  output logic              trap_o,
  output logic              trap_fetch_o
);
  localparam int PN_W = ADDR_W - PAGE_BITS;

  logic [STS_W-1:0] base;
  logic [STS_W-1:0] merged;

  assign base   = (sts_o != '0) ? STS_W'(1) : '0;
  assign merged = base | {idx_i, ft_i, 1'b1, 1'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts_o        <= '0;
      far_o        <= '0;
      trap_o       <= 1'b0;
      trap_fetch_o <= 1'b0;
    end else begin
      trap_o       <= fault_i;
      trap_fetch_o <= fault_i & fetch_i;
      if (fault_i) begin
        sts_o <= merged;
        far_o <= {addr_i[ADDR_W-1:PAGE_BITS], {PAGE_BITS{1'b0}}};
      end else if (sts_rd_i) begin
        sts_o <= '0;
      end
    end
  end

  logic [PN_W-1:0] unused_pn;
  assign unused_pn = far_o[ADDR_W-1:PAGE_BITS];
endmodule

// File: rtl/mmu_access_check.sv
module mmu_access_check
  import mmu_chk_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chk_valid_i,
  input  logic [1:0]        acc_kind_i,
  input  logic              supervisor_i,
  input  logic [2:0]        perm_code_i,
  input  logic              modified_i,
  input  logic              nofault_en_i,
  input  logic [ADDR_W-1:0] vaddr_i,
  input  logic              sts_rd_i,
  output logic [2:0]        fault_type_o,
  output logic              grant_r_o,
  output logic              grant_w_o,
  output logic              grant_x_o,
  output logic              trap_o,
  output logic              trap_fetch_o,
  output logic [7:0]        status_o,
  output logic [ADDR_W-1:0] fault_addr_o
);
  logic [2:0] idx;
  rights_t    grant;
  logic       fault_evt;

  mmu_perm_decode u_dec (
    .kind_i     (acc_kind_i),
    .super_i    (supervisor_i),
    .code_i     (perm_code_i),
    .modified_i (modified_i),
    .nofault_i  (nofault_en_i),
    .idx_o      (idx),
    .ft_o       (fault_type_o),
    .grant_o    (grant)
  );

  assign grant_r_o = grant.r;
  assign grant_w_o = grant.w;
  assign grant_x_o = grant.x;
  assign fault_evt = chk_valid_i && (fault_type_o != FT_NONE);

  mmu_fault_regs #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .fault_i      (fault_evt),
    .idx_i        (idx),
    .ft_i         (fault_type_o),
    .fetch_i      (acc_kind_i == ACC_FETCH),
    .addr_i       (vaddr_i),
    .sts_rd_i     (sts_rd_i),
    .sts_o        (status_o),
    .far_o        (fault_addr_o),
    .trap_o       (trap_o),
    .trap_fetch_o (trap_fetch_o)
  );
endmodule

// File: rtl/mmu_access_check_sva.sv
module mmu_access_check_sva #(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              chk_valid_i,
  input logic              supervisor_i,
  input logic [2:0]        perm_code_i,
  input logic              modified_i,
  input logic              nofault_en_i,
  input logic              sts_rd_i,
  input logic [2:0]        fault_type_o,
  input logic              grant_w_o,
  input logic              trap_o,
  input logic              trap_fetch_o,
  input logic [7:0]        status_o,
  input logic [ADDR_W-1:0] fault_addr_o
);
  logic evt;
  assign evt = chk_valid_i && (fault_type_o != 3'd0);

  // R11
  trap_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> trap_o);

  // R11
  trap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !evt |=> (!trap_o && !trap_fetch_o));

  // R9
  far_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !evt |=> $stable(fault_addr_o));

  // R9
  far_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_addr_o[PAGE_BITS-1:0] == '0);

  // R7
  sts_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> status_o[1]);

  // R5
  wr_mod_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_w_o |-> modified_i);

  // R10
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_rd_i && !evt) |=> (status_o == 8'd0));

  // R6
  nofault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nofault_en_i && !supervisor_i) |-> (fault_type_o == 3'd0));

  // R2
  priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!supervisor_i && !nofault_en_i && perm_code_i[2:1] == 2'b11) |-> (fault_type_o == 3'd3));
endmodule

bind mmu_access_check mmu_access_check_sva #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_sva (
  .clk          (clk),
  .rst_n        (rst_n),
  .chk_valid_i  (chk_valid_i),
  .supervisor_i (supervisor_i),
  .perm_code_i  (perm_code_i),
  .modified_i   (modified_i),
  .nofault_en_i (nofault_en_i),
  .sts_rd_i     (sts_rd_i),
  .fault_type_o (fault_type_o),
  .grant_w_o    (grant_w_o),
  .trap_o       (trap_o),
  .trap_fetch_o (trap_fetch_o),
  .status_o     (status_o),
  .fault_addr_o (fault_addr_o)
);

// File: tb/tb_mmu_access_check.sv
module tb_mmu_access_check;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chk_valid_i = 1'b0;
  logic [1:0]  acc_kind_i = 2'd0;
  logic        supervisor_i = 1'b0;
  logic [2:0]  perm_code_i = 3'd0;
  logic        modified_i = 1'b0;
  logic        nofault_en_i = 1'b0;
  logic [31:0] vaddr_i = 32'd0;
  logic        sts_rd_i = 1'b0;
  logic [2:0]  fault_type_o;
  logic        grant_r_o, grant_w_o, grant_x_o;
  logic        trap_o, trap_fetch_o;
  logic [7:0]  status_o;
  logic [31:0] fault_addr_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mmu_access_check dut (
    .clk(clk), .rst_n(rst_n), .chk_valid_i(chk_valid_i), .acc_kind_i(acc_kind_i),
    .supervisor_i(supervisor_i), .perm_code_i(perm_code_i), .modified_i(modified_i),
    .nofault_en_i(nofault_en_i), .vaddr_i(vaddr_i), .sts_rd_i(sts_rd_i),
    .fault_type_o(fault_type_o), .grant_r_o(grant_r_o), .grant_w_o(grant_w_o),
    .grant_x_o(grant_x_o), .trap_o(trap_o), .trap_fetch_o(trap_fetch_o),
    .status_o(status_o), .fault_addr_o(fault_addr_o)
  );

  // row: kind[13:12] sup[11] code[10:8] mod[7] nf[6] ft[5:3] rwx[2:0]
  localparam int NV = 18;
  localparam logic [13:0] VEC [NV] = '{
    {2'd0, 1'b0, 3'd0, 1'b1, 1'b0, 3'd0, 3'b100},
    {2'd0, 1'b0, 3'd4, 1'b1, 1'b0, 3'd2, 3'b001},
    {2'd0, 1'b0, 3'd6, 1'b1, 1'b0, 3'd3, 3'b000},
    {2'd0, 1'b1, 3'd4, 1'b1, 1'b0, 3'd2, 3'b001},
    {2'd0, 1'b1, 3'd7, 1'b1, 1'b0, 3'd0, 3'b111},
    {2'd0, 1'b1, 3'd7, 1'b0, 1'b0, 3'd0, 3'b101},
    {2'd1, 1'b0, 3'd1, 1'b1, 1'b0, 3'd0, 3'b110},
    {2'd1, 1'b0, 3'd5, 1'b1, 1'b0, 3'd2, 3'b100},
    {2'd1, 1'b1, 3'd5, 1'b1, 1'b0, 3'd0, 3'b110},
    {2'd1, 1'b1, 3'd6, 1'b1, 1'b0, 3'd2, 3'b101},
    {2'd2, 1'b0, 3'd2, 1'b1, 1'b0, 3'd0, 3'b101},
    {2'd2, 1'b0, 3'd5, 1'b1, 1'b0, 3'd2, 3'b100},
    {2'd2, 1'b1, 3'd5, 1'b1, 1'b0, 3'd2, 3'b110},
    {2'd2, 1'b1, 3'd6, 1'b1, 1'b0, 3'd0, 3'b101},
    {2'd1, 1'b0, 3'd7, 1'b1, 1'b1, 3'd0, 3'b000},
    {2'd0, 1'b0, 3'd4, 1'b1, 1'b1, 3'd0, 3'b001},
    {2'd1, 1'b1, 3'd2, 1'b1, 1'b1, 3'd2, 3'b101},
    {2'd2, 1'b0, 3'd7, 1'b0, 1'b0, 3'd3, 3'b000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [1:0] k, input logic s, input logic [2:0] c,
                       input logic m, input logic nf, input logic [31:0] a, input logic rd);
    chk_valid_i = v; acc_kind_i = k; supervisor_i = s; perm_code_i = c;
    modified_i = m; nofault_en_i = nf; vaddr_i = a; sts_rd_i = rd;
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk("R12 status", {24'd0, status_o}, 32'h0);
    chk("R12 far", fault_addr_o, 32'h0);
    chk("R12 trap", {30'd0, trap_o, trap_fetch_o}, 32'h0);

    // table walk with check strobe low: combinational results only
    for (int i = 0; i < NV; i++) begin
      drive(1'b0, VEC[i][13:12], VEC[i][11], VEC[i][10:8], VEC[i][7], VEC[i][6], 32'h0, 1'b0);
      #1;
      chk($sformatf("R2 R3 R6 fault row %0d", i), {29'd0, fault_type_o}, {29'd0, VEC[i][5:3]});
      chk($sformatf("R4 R5 rights row %0d", i), {29'd0, grant_r_o, grant_w_o, grant_x_o},
          {29'd0, VEC[i][2:0]});
      @(negedge clk);
    end
    step();
    chk("R6 table walk left status", {24'd0, status_o}, 32'h0);

    // R1 R7 R9 R11: user store, code 5 -> idx 4, prot
    drive(1'b1, 2'd1, 1'b0, 3'd5, 1'b1, 1'b0, 32'h1234_5ABC, 1'b0);
    step();
    drive(1'b0, 2'd0, 1'b0, 3'd0, 1'b1, 1'b0, 32'h0, 1'b0);
    chk("R1 R7 status", {24'd0, status_o}, 32'h8A);
    chk("R9 far", fault_addr_o, 32'h1234_5000);
    chk("R11 trap data", {30'd0, trap_o, trap_fetch_o}, 32'h2);
    step();
    chk("R11 single pulse", {30'd0, trap_o, trap_fetch_o}, 32'h0);

    // R8: second fault without read, user fetch code 6 -> idx 2, priv
    drive(1'b1, 2'd2, 1'b0, 3'd6, 1'b1, 1'b0, 32'hABCD_E123, 1'b0);
    step();
    drive(1'b0, 2'd0, 1'b0, 3'd0, 1'b1, 1'b0, 32'h0, 1'b0);
    chk("R8 overwrite status", {24'd0, status_o}, 32'h4F);
    chk("R11 trap fetch", {30'd0, trap_o, trap_fetch_o}, 32'h3);
    chk("R9 far second", fault_addr_o, 32'hABCD_E000);

    // R10 read clears
    step();
    sts_rd_i = 1'b1;
    #1;
    chk("R10 read value", {24'd0, status_o}, 32'h4F);
    step();
    sts_rd_i = 1'b0;
    chk("R10 cleared", {24'd0, status_o}, 32'h0);

    // R6 suppressed user fault leaves registers
    drive(1'b1, 2'd1, 1'b0, 3'd6, 1'b1, 1'b1, 32'h3333_3000, 1'b0);
    step();
    drive(1'b0, 2'd0, 1'b0, 3'd0, 1'b1, 1'b0, 32'h0, 1'b0);
    chk("R6 status untouched", {24'd0, status_o}, 32'h0);
    chk("R6 no trap", {31'd0, trap_o}, 32'h0);
    chk("R6 far untouched", fault_addr_o, 32'hABCD_E000);

    // sup load code 4 -> idx 1 prot
    drive(1'b1, 2'd0, 1'b1, 3'd4, 1'b1, 1'b0, 32'h0000_2FFF, 1'b0);
    step();
    chk("R1 R7 sup load", {24'd0, status_o}, 32'h2A);
    chk("R9 far low", fault_addr_o, 32'h0000_2000);

    // R10 read and fault in the same cycle: sup store code 6 -> idx 5 prot
    drive(1'b1, 2'd1, 1'b1, 3'd6, 1'b1, 1'b0, 32'h7000_0010, 1'b1);
    step();
    drive(1'b0, 2'd0, 1'b1, 3'd7, 1'b1, 1'b0, 32'h0, 1'b0);
    chk("R10 fault wins over read", {24'd0, status_o}, 32'hAB);
    chk("R9 far store", fault_addr_o, 32'h7000_0000);

    // R9 allowed check leaves far
    drive(1'b1, 2'd0, 1'b1, 3'd7, 1'b1, 1'b0, 32'h5555_5555, 1'b0);
    step();
    drive(1'b0, 2'd0, 1'b0, 3'd0, 1'b1, 1'b0, 32'h0, 1'b0);
    chk("R9 far held", fault_addr_o, 32'h7000_0000);
    chk("R11 no trap when allowed", {31'd0, trap_o}, 32'h0);

    // R12 reset mid-run
    rst_n = 1'b0;
    step();
    rst_n = 1'b1;
    chk("R12 status after reset", {24'd0, status_o}, 32'h0);
    chk("R12 far after reset", fault_addr_o, 32'h0);

    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
    end
  end
endmodule